// File: doc/BRIEF.md
# Store Buffer with Load Bypassing

This block sits between a processor's memory port and the memory system. Stores from the processor are taken into a small circular queue and written out to memory one at a time, oldest first, over a valid/ready request channel. Loads do not wait behind these stores. A load is compared with every queued store. If the addresses match, the load is answered from the youngest matching store and memory never sees it. If nothing matches, the load takes the memory port ahead of any store that is waiting to drain.

Only one memory read may be outstanding at a time. A forwarded load answers one cycle after it is accepted. A load that goes to memory answers in the cycle memory returns its data. The full, empty and drained flags tell the processor when stores must stall and when all of its traffic has settled.

Top module: `stb_bypass`

## Requirements
- R1: After reset the buffer is empty: `empty_o`=1, `full_o`=0, `drained_o`=1, `mem_req_valid_o`=0 and `ld_rsp_valid_o`=0.
- R2: A store is accepted (`st_ready_o`=1) whenever fewer than DEPTH entries are held. `full_o` rises after DEPTH stores that have not drained, and while it is high `st_ready_o` is 0.
- R3: While no load needs the port and the buffer is not empty, the block presents a write (`mem_req_we_o`=1) carrying the oldest entry's address and data. The entry is freed only in a cycle where `mem_req_ready_i` is 1, and entries leave in the order they arrived.
- R4: A load that is valid, matches no entry and has no read pending takes the memory port in the same cycle, ahead of any waiting write: `mem_req_we_o`=0 and `mem_req_addr_o` equals the load address.
- R5: A load that matches a buffered store is accepted without a memory request. One cycle later it is answered on `ld_rsp_valid_o`/`ld_rsp_data_o` with the buffered data.
- R6: When several buffered stores match a load, the data comes from the one accepted most recently.
- R7: A store and a load presented in the same cycle are ordered store-first. If their addresses are equal, the load is forwarded the data of that new store.
- R8: Loads are still accepted while the buffer is full.
- R9: A load that misses is accepted when memory takes its read. `ld_ready_o` stays 0 until `mem_rsp_valid_i` returns, and that response is passed to `ld_rsp_valid_o`/`ld_rsp_data_o` in the same cycle.
- R10: `empty_o` is 1 exactly when no entry is held. `drained_o` is 1 exactly when no entry is held and no memory read is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Processor store request |
| st_ready_o | output | 1 | Store can be accepted |
| st_addr_i | input | AW | Store address |
| st_data_i | input | DW | Store data |
| ld_valid_i | input | 1 | Processor load request |
| ld_ready_o | output | 1 | Load accepted this cycle |
| ld_addr_i | input | AW | Load address |
| ld_rsp_valid_o | output | 1 | Load result valid |
| ld_rsp_data_o | output | DW | Load result data |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory takes the request |
| mem_req_we_o | output | 1 | 1 = write (drained store), 0 = read (load) |
| mem_req_addr_o | output | AW | Request address |
| mem_req_wdata_o | output | DW | Write data |
| mem_rsp_valid_i | input | 1 | Read data returned |
| mem_rsp_rdata_i | input | DW | Read data |
| full_o | output | 1 | DEPTH entries held |
| empty_o | output | 1 | No entry held |
| drained_o | output | 1 | Empty and no read pending |

## Verification
The assertions assume that memory returns exactly one `mem_rsp_valid_i` pulse for each read it accepts, and none while no read is pending. They also assume that memory does not require a request to stay unchanged until it is taken, because a load can replace a write that is waiting. The bench memory model responds a fixed two cycles after it takes a read, and only once per read. It applies each write as it takes it, and it lowers `mem_req_ready_i` for long stretches so that the buffer fills. Addresses come from a set of four, so that forwarding from several matching entries and from a store in the same cycle happens often.

// File: rtl/stb_pkg.sv
package stb_pkg;
  typedef enum logic {
    MEM_RD = 1'b0,
    MEM_WR = 1'b1
  } mem_op_e;
endpackage

// File: rtl/stb_fifo.sv
module stb_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      push_i,
  input  logic [AW-1:0]             push_addr_i,
  input  logic [DW-1:0]             push_data_i,
  input  logic                      pop_i,
  output logic [DEPTH-1:0][AW-1:0]  addr_o,
  output logic [DEPTH-1:0][DW-1:0]  data_o,
  output logic [PW-1:0]             rd_ptr_o,
  output logic [CW-1:0]             count_o,
  output logic                      full_o,
  output logic                      empty_o
);
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
      count_q <= count_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[wr_ptr_q] <= push_addr_i;
      data_q[wr_ptr_q] <= push_data_i;
    end
  end

  assign addr_o   = addr_q;
  assign data_o   = data_q;
  assign rd_ptr_o = rd_ptr_q;
  assign count_o  = count_q;
  assign full_o   = (count_q == CW'(DEPTH));
  assign empty_o  = (count_q == '0);

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_no_underflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/stb_match.sv
module stb_match #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][AW-1:0] addr_i,
  input  logic [DEPTH-1:0][DW-1:0] data_i,
  input  logic [PW-1:0]            rd_ptr_i,
  input  logic [CW-1:0]            count_i,
  input  logic [AW-1:0]            ld_addr_i,
  input  logic                     new_vld_i,
  input  logic [AW-1:0]            new_addr_i,
  input  logic [DW-1:0]            new_data_i,
  output logic                     hit_o,
  output logic [DW-1:0]            data_o
);
  // walk oldest to youngest, last match wins; a same-cycle store is youngest
  always_comb begin
    logic [PW-1:0] idx;
    hit_o  = 1'b0;
    data_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = rd_ptr_i + PW'(k);
      if ((CW'(k) < count_i) && (addr_i[idx] == ld_addr_i)) begin
        hit_o  = 1'b1;
        data_o = data_i[idx];
      end
    end
    if (new_vld_i && (new_addr_i == ld_addr_i)) begin
      hit_o  = 1'b1;
      data_o = new_data_i;
    end
  end
endmodule

// File: rtl/stb_bypass.sv
module stb_bypass
  import stb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_valid_i,
  output logic          st_ready_o,
  input  logic [AW-1:0] st_addr_i,
  input  logic [DW-1:0] st_data_i,
  input  logic          ld_valid_i,
  output logic          ld_ready_o,
  input  logic [AW-1:0] ld_addr_i,
  output logic          ld_rsp_valid_o,
  output logic [DW-1:0] ld_rsp_data_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_req_we_o,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [DW-1:0] mem_req_wdata_o,
  input  logic          mem_rsp_valid_i,
  input  logic [DW-1:0] mem_rsp_rdata_i,
  output logic          full_o,
  output logic          empty_o,
  output logic          drained_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][AW-1:0] ent_addr;
  logic [DEPTH-1:0][DW-1:0] ent_data;
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] count;
  logic full, empty;
  logic st_fire, wr_fire, rd_fire, ld_fire;
  logic hit, ld_miss;
  logic [DW-1:0] hit_data;
  logic rd_pend_q, fwd_vld_q;
  logic [DW-1:0] fwd_data_q;
  mem_op_e op;

  assign st_ready_o = !full;
  assign st_fire    = st_valid_i && !full;

  stb_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (st_fire),
    .push_addr_i (st_addr_i),
    .push_data_i (st_data_i),
    .pop_i       (wr_fire),
    .addr_o      (ent_addr),
    .data_o      (ent_data),
    .rd_ptr_o    (rd_ptr),
    .count_o     (count),
    .full_o      (full),
    .empty_o     (empty)
  );

  stb_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
    .addr_i     (ent_addr),
    .data_i     (ent_data),
    .rd_ptr_i   (rd_ptr),
    .count_i    (count),
    .ld_addr_i  (ld_addr_i),
    .new_vld_i  (st_fire),
    .new_addr_i (st_addr_i),
    .new_data_i (st_data_i),
    .hit_o      (hit),
    .data_o     (hit_data)
  );

  // load miss owns the port; otherwise the head store drains
  assign ld_miss         = ld_valid_i && !rd_pend_q && !hit;
  assign op              = ld_miss ? MEM_RD : MEM_WR;
  assign mem_req_valid_o = ld_miss || !empty;
  assign mem_req_we_o    = (op == MEM_WR);
  assign mem_req_addr_o  = ld_miss ? ld_addr_i : ent_addr[rd_ptr];
  assign mem_req_wdata_o = ld_miss ? '0 : ent_data[rd_ptr];

  assign wr_fire    = !ld_miss && !empty && mem_req_ready_i;
  assign rd_fire    = ld_miss && mem_req_ready_i;
  assign ld_ready_o = !rd_pend_q && (hit || mem_req_ready_i);
  assign ld_fire    = ld_valid_i && ld_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q  <= 1'b0;
      fwd_vld_q  <= 1'b0;
      fwd_data_q <= '0;
    end else begin
      if (rd_fire)              rd_pend_q <= 1'b1;
      else if (mem_rsp_valid_i) rd_pend_q <= 1'b0;
      fwd_vld_q <= ld_fire && hit;
      if (ld_fire && hit) fwd_data_q <= hit_data;
    end
  end

  assign ld_rsp_valid_o = fwd_vld_q || mem_rsp_valid_i;
  assign ld_rsp_data_o  = fwd_vld_q ? fwd_data_q : mem_rsp_rdata_i;
  assign full_o         = full;
  assign empty_o        = empty;
  assign drained_o      = empty && !rd_pend_q;

  p_load_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && !rd_pend_q && !hit && !empty) |-> (mem_req_valid_o && !mem_req_we_o));
  p_hit_no_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_fire && hit) |-> !(mem_req_valid_o && !mem_req_we_o));
  p_fwd_resp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_fire && hit) |=> ld_rsp_valid_o);
  p_store_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_we_o && !mem_req_ready_i) |=> !empty_o);
  p_rsp_expected_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rsp_valid_i |-> rd_pend_q);
  p_one_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_pend_q) |-> !ld_ready_o);
  p_drained_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drained_o |-> !(mem_req_valid_o && mem_req_we_o));
endmodule

// File: tb/stb_bypass_bench.sv
module stb_bypass_bench;
  localparam int DEPTH = 4;
  localparam int AW    = 8;
  localparam int DW    = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic st_valid_i = 0, ld_valid_i = 0, mem_req_ready_i = 0, mem_rsp_valid_i = 0;
  logic [AW-1:0] st_addr_i = '0, ld_addr_i = '0;
  logic [DW-1:0] st_data_i = '0, mem_rsp_rdata_i = '0;
  logic st_ready_o, ld_ready_o, ld_rsp_valid_o, mem_req_valid_o, mem_req_we_o;
  logic full_o, empty_o, drained_o;
  logic [DW-1:0] ld_rsp_data_o, mem_req_wdata_o;
  logic [AW-1:0] mem_req_addr_o;

  always #10 clk = ~clk;

  stb_bypass #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_stb_bypass (
    .clk_i(clk), .rst_ni(rst_ni),
    .st_valid_i(st_valid_i), .st_ready_o(st_ready_o), .st_addr_i(st_addr_i), .st_data_i(st_data_i),
    .ld_valid_i(ld_valid_i), .ld_ready_o(ld_ready_o), .ld_addr_i(ld_addr_i),
    .ld_rsp_valid_o(ld_rsp_valid_o), .ld_rsp_data_o(ld_rsp_data_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_we_o(mem_req_we_o), .mem_req_addr_o(mem_req_addr_o), .mem_req_wdata_o(mem_req_wdata_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_rdata_i(mem_rsp_rdata_i),
    .full_o(full_o), .empty_o(empty_o), .drained_o(drained_o)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model state
  logic [AW-1:0] qa[$];
  logic [DW-1:0] qd[$];
  logic [DW-1:0] mem_m [int];
  bit m_rd_pend = 0;
  int lat = 0;
  logic [DW-1:0] rd_cap = '0;
  bit fwd_pend = 0;
  logic [DW-1:0] fwd_exp = '0;
  string fwd_tag = "R5";

  function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
    if (mem_m.exists(int'(a))) return mem_m[int'(a)];
    return '0;
  endfunction

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit e_full, e_hit, e_miss, e_mvalid, e_we, e_ldrdy, sfire;
    int nm;
    logic [DW-1:0] e_hd;
    logic [AW-1:0] e_addr;
    string htag;

    repeat (2) @(negedge clk);
    chk("R1", "empty_o", empty_o, 1);
    chk("R1", "full_o", full_o, 0);
    chk("R1", "drained_o", drained_o, 1);
    chk("R1", "mem_req_valid_o", mem_req_valid_o, 0);
    chk("R1", "ld_rsp_valid_o", ld_rsp_valid_o, 0);
    rst_ni = 1'b1;

    for (int c = 0; c < 1600; c++) begin
      @(negedge clk);
      mem_rsp_valid_i = 1'b0;
      if (m_rd_pend) begin
        lat--;
        if (lat == 0) begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_rdata_i = rd_cap;
        end
      end
      if (c < 40)        mem_req_ready_i = 1'b0;
      else if (c < 1500) mem_req_ready_i = ($urandom_range(0, 9) < 7);
      else               mem_req_ready_i = 1'b1;
      st_valid_i = 1'b0;
      ld_valid_i = 1'b0;
      if (c == 0)      begin st_valid_i = 1; st_addr_i = 8'd1; st_data_i = 16'h0111; end
      else if (c == 1) begin st_valid_i = 1; st_addr_i = 8'd1; st_data_i = 16'h0222; end
      else if (c == 2) begin ld_valid_i = 1; ld_addr_i = 8'd1; end  // R6: expect 0222
      else if (c == 3) begin                                         // R7: same-cycle store/load
        st_valid_i = 1; st_addr_i = 8'd2; st_data_i = 16'h0333;
        ld_valid_i = 1; ld_addr_i = 8'd2;
      end else if (c < 1500) begin
        st_valid_i = ($urandom_range(0, 9) < 5);
        st_addr_i  = AW'($urandom_range(0, 3));
        st_data_i  = DW'($urandom);
        ld_valid_i = ($urandom_range(0, 9) < 5);
        ld_addr_i  = AW'($urandom_range(0, 3));
      end
      #1;
      e_full = (qa.size() == DEPTH);
      sfire  = st_valid_i && !e_full;
      e_hit = 0; nm = 0; e_hd = '0; htag = "R5";
      foreach (qa[i]) if (qa[i] == ld_addr_i) begin e_hit = 1; e_hd = qd[i]; nm++; end
      if (nm > 1) htag = "R6";
      if (sfire && st_addr_i == ld_addr_i) begin e_hit = 1; e_hd = st_data_i; htag = "R7"; end
      e_miss   = ld_valid_i && !m_rd_pend && !e_hit;
      e_mvalid = e_miss || (qa.size() > 0);
      e_we     = !e_miss;
      e_addr   = e_miss ? ld_addr_i : (qa.size() > 0 ? qa[0] : '0);
      e_ldrdy  = !m_rd_pend && (e_hit || mem_req_ready_i);

      chk("R2", "st_ready_o", st_ready_o, !e_full);
      chk("R2", "full_o", full_o, e_full);
      chk("R10", "empty_o", empty_o, qa.size() == 0);
      chk("R10", "drained_o", drained_o, (qa.size() == 0) && !m_rd_pend);
      if (ld_valid_i) chk(e_full ? "R8" : "R9", "ld_ready_o", ld_ready_o, e_ldrdy);
      chk(e_miss ? "R4" : "R3", "mem_req_valid_o", mem_req_valid_o, e_mvalid);
      if (e_mvalid) begin
        chk(e_miss ? "R4" : "R3", "mem_req_we_o", mem_req_we_o, e_we);
        chk(e_miss ? "R4" : "R3", "mem_req_addr_o", mem_req_addr_o, e_addr);
        if (e_we) chk("R3", "mem_req_wdata_o", mem_req_wdata_o, qd[0]);
      end
      chk(fwd_pend ? fwd_tag : "R9", "ld_rsp_valid_o", ld_rsp_valid_o, fwd_pend || mem_rsp_valid_i);
      if (fwd_pend)             chk(fwd_tag, "ld_rsp_data_o", ld_rsp_data_o, fwd_exp);
      else if (mem_rsp_valid_i) chk("R9", "ld_rsp_data_o", ld_rsp_data_o, rd_cap);

      // next state of the model
      fwd_pend = ld_valid_i && e_ldrdy && e_hit;
      if (fwd_pend) begin fwd_exp = e_hd; fwd_tag = htag; end
      if (mem_rsp_valid_i) m_rd_pend = 0;
      if (e_mvalid && mem_req_ready_i) begin
        if (e_we) begin
          mem_m[int'(qa[0])] = qd[0];
          void'(qa.pop_front());
          void'(qd.pop_front());
        end else begin
          m_rd_pend = 1;
          lat = 2;
          rd_cap = mem_rd(ld_addr_i);
        end
      end
      if (sfire) begin qa.push_back(st_addr_i); qd.push_back(st_data_i); end
    end

    @(negedge clk);
    chk("R10", "drained_o at end", drained_o, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule